// File: doc/BRIEF.md
# Multiplexed-Bus Register Address Decoder

This block sits between an 8-bit shared address/data bus and the register file of a two-channel serial controller. The bus runs in two steps. In the first step, an address byte is on the bus and the address strobe goes low and then high. The block captures and decodes that byte when the strobe returns high. In the second step, the data strobe marks a read or a write. During that step the block presents a 4-bit register index and a channel selection. Both stay steady until the next address step.

The position of the register index and the channel bit inside the address byte depends on a mode bit.
- **Shift-left mode** is the mode after reset. The index comes from bits 4..1 and the channel bit from bit 5.
- **Shift-right mode** takes the index from bits 5..2 and the channel bit from bit 0.

The mode bit lives in a write-once configuration register. The first write data phase after reset lands in that register, whatever address was captured. Later writes no longer reach it until the next reset.

The channel selection combines the captured address bit with an external channel pin. Channel A is coded 1 and channel B is coded 0 on both sources. Channel A results only when both sources say A. So to steer the channel with one source, the other must sit at the A value. All strobes are sampled on the block clock.

Top module: `mux_reg_addr_decoder`

## Requirements
- R1: After a synchronous reset, `reg_sel_o` is 0, `shift_right_o` is 0 (shift-left mode), `cfg_sel_o` is 1 and the captured channel bit reads as channel A (1), so `chan_a_o` follows `chan_a_pin_i`.
- R2: In shift-left mode (`shift_right_o`=0), one clock edge after the address strobe is seen high following a low sample, `reg_sel_o` equals bits 4..1 of the bus and the captured channel bit equals bus bit 5.
- R3: In shift-right mode (`shift_right_o`=1), one clock edge after a rising address strobe, `reg_sel_o` equals bus bits 5..2 and the captured channel bit equals bus bit 0.
- R4: Between address-strobe rising edges, changes on the bus leave `reg_sel_o` and the captured channel bit unchanged.
- R5: `chan_a_o` is 1 (channel A) only when both the captured channel bit and `chan_a_pin_i` are 1; otherwise it is 0 (channel B).
- R6: While `cfg_sel_o` is 1, a write data phase (data strobe falling with `wr_i`=1) loads bus bit 0 into the mode bit (1 = shift-right) and clears `cfg_sel_o` one edge later.
- R7: Once `cfg_sel_o` is 0, further writes change neither the mode bit nor `cfg_sel_o` until reset.
- R8: A read data phase (`wr_i`=0) leaves `cfg_sel_o` at 1 and the mode bit unchanged.
- R9: A mode change affects only addresses captured afterwards. The index already captured stays on `reg_sel_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ad_i | input | 8 | Multiplexed address/data bus |
| as_n_i | input | 1 | Address strobe, active low; address captured on its rising edge |
| ds_n_i | input | 1 | Data strobe, active low; data phase begins on its falling edge |
| wr_i | input | 1 | Data phase direction, 1 = write, 0 = read |
| chan_a_pin_i | input | 1 | External channel pin, 1 = channel A, 0 = channel B |
| reg_sel_o | output | 4 | Decoded register index for the data phase |
| chan_a_o | output | 1 | Merged channel select, 1 = channel A, 0 = channel B |
| cfg_sel_o | output | 1 | 1 while the next write will land in the configuration register |
| shift_right_o | output | 1 | Current placement mode, 1 = shift-right |

## Verification
The assertions assume that the address strobe rising edge and the data strobe falling edge never fall on the same clock edge. They also assume each strobe level is held for at least one clock, so that every transition is sampled. The bench drives each strobe level for whole clock periods and finishes each bus phase before starting the next, which keeps it inside both assumptions. The channel pin is taken to be steady while the block is in use. The bench changes it only between checks and samples `chan_a_o` after the change has settled.

// File: rtl/mux_dec_pkg.sv
// Package: shared constants and the placement-mode type for the
// multiplexed-bus register address decoder.
package mux_dec_pkg;
    // Placement of register index and channel bit within the address byte.
    typedef enum logic {
        PLACE_LEFT  = 1'b0,
        PLACE_RIGHT = 1'b1
    } place_e;

    // Channel-select coding shared by the address bit and the pin.
    localparam logic CHAN_A = 1'b1;
    localparam logic CHAN_B = 1'b0;
endpackage

// File: rtl/mux_strobe_edge.sv
// Strobe edge detector.
// Does: samples an asynchronous-looking strobe level on clk and emits a
// one-cycle pulse on the selected transition (rising or falling).
// Assumes: each strobe level persists for at least one clock period;
// the sampled history resets to the strobe's idle (high) level.
module mux_strobe_edge #(
    parameter bit RISING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    output logic edge_o
);
    logic prev_q;

    // Keep the previous sampled level of the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= strobe_i;
    end

    // Pick the transition that this instance reports.
    generate
        if (RISING) begin : g_rise
            assign edge_o = strobe_i & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~strobe_i & prev_q;
        end
    endgenerate
endmodule

// File: rtl/mux_addr_decode.sv
// Address byte decoder.
// Does: extracts the register index and the channel bit from an address
// byte. Both placements are built and one is chosen by the mode input.
// Assumes: the bit positions given by the parameters fit inside AD_W.
module mux_addr_decode
    import mux_dec_pkg::*;
#(
    parameter int AD_W       = 8,
    parameter int IDX_W      = 4,
    parameter int SL_IDX_LSB = 1,
    parameter int SL_CH_BIT  = 5,
    parameter int SR_IDX_LSB = 2,
    parameter int SR_CH_BIT  = 0
) (
    input  logic [AD_W-1:0]  ad_i,
    input  place_e           mode_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             chan_o
);
    logic [IDX_W-1:0] idx_left, idx_right;

    // Form the index under each placement.
    always_comb begin
        idx_left  = IDX_W'(ad_i >> SL_IDX_LSB);
        idx_right = IDX_W'(ad_i >> SR_IDX_LSB);
    end

    // Choose the placement that the current mode selects.
    always_comb begin
        if (mode_i == PLACE_RIGHT) begin
            idx_o  = idx_right;
            chan_o = ad_i[SR_CH_BIT];
        end else begin
            idx_o  = idx_left;
            chan_o = ad_i[SL_CH_BIT];
        end
    end
endmodule

// File: rtl/mux_cfg_once.sv
// Write-once bus configuration register.
// Does: holds the placement mode. The first write strobe after reset
// loads it and then locks it.
// Assumes: wr_evt_i is a single-cycle pulse for each write data phase.
module mux_cfg_once
    import mux_dec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_evt_i,
    input  logic   mode_bit_i,
    output place_e mode_o,
    output logic   open_o
);
    logic locked_q;
    place_e mode_q;

    // Load the mode on the first write, then lock until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locked_q <= 1'b0;
            mode_q   <= PLACE_LEFT;
        end else if (wr_evt_i && !locked_q) begin
            locked_q <= 1'b1;
            mode_q   <= place_e'(mode_bit_i);
        end
    end

    assign mode_o = mode_q;
    assign open_o = ~locked_q;
endmodule

// File: rtl/mux_reg_addr_decoder.sv
// Multiplexed-bus register address decoder (top).
// Does: captures the decoded address on the address-strobe rising edge,
// merges the channel bit with the channel pin, and sends the first
// write after reset to the write-once configuration register.
// Assumes: address-strobe rise and data-strobe fall do not share an edge.
// The channel pin is steady during use.
module mux_reg_addr_decoder
    import mux_dec_pkg::*;
#(
    parameter int AD_W         = 8,
    parameter int IDX_W        = 4,
    parameter int SL_IDX_LSB   = 1,
    parameter int SL_CH_BIT    = 5,
    parameter int SR_IDX_LSB   = 2,
    parameter int SR_CH_BIT    = 0,
    parameter int CFG_MODE_BIT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AD_W-1:0]  ad_i,
    input  logic             as_n_i,
    input  logic             ds_n_i,
    input  logic             wr_i,
    input  logic             chan_a_pin_i,
    output logic [IDX_W-1:0] reg_sel_o,
    output logic             chan_a_o,
    output logic             cfg_sel_o,
    output logic             shift_right_o
);
    logic             as_rise, ds_fall, cfg_wr;
    logic [IDX_W-1:0] idx_dec, idx_q;
    logic             chan_dec, chan_q;
    place_e           mode;
    logic             cfg_open;

    mux_strobe_edge #(.RISING(1'b1)) as_edge_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(as_n_i), .edge_o(as_rise)
    );

    mux_strobe_edge #(.RISING(1'b0)) ds_edge_i (
        .clk(clk), .rst_n(rst_n), .strobe_i(ds_n_i), .edge_o(ds_fall)
    );

    mux_addr_decode #(
        .AD_W(AD_W), .IDX_W(IDX_W),
        .SL_IDX_LSB(SL_IDX_LSB), .SL_CH_BIT(SL_CH_BIT),
        .SR_IDX_LSB(SR_IDX_LSB), .SR_CH_BIT(SR_CH_BIT)
    ) dec_i (
        .ad_i(ad_i), .mode_i(mode), .idx_o(idx_dec), .chan_o(chan_dec)
    );

    assign cfg_wr = ds_fall & wr_i;

    mux_cfg_once cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_evt_i(cfg_wr),
        .mode_bit_i(ad_i[CFG_MODE_BIT]), .mode_o(mode), .open_o(cfg_open)
    );

    // Hold the decoded address from one address phase to the next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            chan_q <= CHAN_A;
        end else if (as_rise) begin
            idx_q  <= idx_dec;
            chan_q <= chan_dec;
        end
    end

    // Channel B wins when either source asks for it.
    always_comb begin
        chan_a_o = (chan_q == CHAN_A) && (chan_a_pin_i == CHAN_A);
    end

    assign reg_sel_o     = idx_q;
    assign cfg_sel_o     = cfg_open;
    assign shift_right_o = (mode == PLACE_RIGHT);
endmodule

// File: rtl/mux_reg_addr_decoder_chk.sv
// Checker for the multiplexed-bus register address decoder.
// Does: tracks its own strobe history and checks the port-level rules.
// Assumes: the same strobe timing as the design under check.
module mux_reg_addr_decoder_chk #(
    parameter int AD_W       = 8,
    parameter int IDX_W      = 4,
    parameter int SL_IDX_LSB = 1,
    parameter int SR_IDX_LSB = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AD_W-1:0]  ad_i,
    input logic             as_n_i,
    input logic             ds_n_i,
    input logic             wr_i,
    input logic             chan_a_pin_i,
    input logic [IDX_W-1:0] reg_sel_o,
    input logic             chan_a_o,
    input logic             cfg_sel_o,
    input logic             shift_right_o
);
    logic as_prev, ds_prev;

    // Shadow strobe history, independent of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            as_prev <= 1'b1;
            ds_prev <= 1'b1;
        end else begin
            as_prev <= as_n_i;
            ds_prev <= ds_n_i;
        end
    end

    logic as_up, wr_dn;
    assign as_up = as_n_i & ~as_prev;
    assign wr_dn = ~ds_n_i & ds_prev & wr_i;

    a_r2_left_index: assert property (@(posedge clk) disable iff (!rst_n)
        (as_up && !shift_right_o) |=> reg_sel_o == $past(IDX_W'(ad_i >> SL_IDX_LSB)));

    a_r3_right_index: assert property (@(posedge clk) disable iff (!rst_n)
        (as_up && shift_right_o) |=> reg_sel_o == $past(IDX_W'(ad_i >> SR_IDX_LSB)));

    a_r4_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !as_up |=> $stable(reg_sel_o));

    a_r5_chan_needs_pin: assert property (@(posedge clk) disable iff (!rst_n)
        chan_a_o |-> chan_a_pin_i);

    a_r6_first_write_locks: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_o && wr_dn) |=> !cfg_sel_o);

    a_r7_locked_stays: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_sel_o |=> (!cfg_sel_o && $stable(shift_right_o)));

    a_r8_open_until_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_o && !wr_dn) |=> (cfg_sel_o && $stable(shift_right_o)));
endmodule

bind mux_reg_addr_decoder mux_reg_addr_decoder_chk #(
    .AD_W(AD_W), .IDX_W(IDX_W),
    .SL_IDX_LSB(SL_IDX_LSB), .SR_IDX_LSB(SR_IDX_LSB)
) chk_i (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .as_n_i(as_n_i),
    .ds_n_i(ds_n_i), .wr_i(wr_i), .chan_a_pin_i(chan_a_pin_i),
    .reg_sel_o(reg_sel_o), .chan_a_o(chan_a_o),
    .cfg_sel_o(cfg_sel_o), .shift_right_o(shift_right_o)
);

// File: tb/mux_reg_addr_decoder_tb.sv
// Bench: sweeps every address byte in both placement modes with both
// pin values, and checks reset, configuration lock and hold behaviour.
module mux_reg_addr_decoder_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ad = 8'h00;
    logic       as_n = 1'b1, ds_n = 1'b1, wr = 1'b0, pin = 1'b1;
    logic [3:0] reg_sel;
    logic       chan_a, cfg_sel, shift_right;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5ns clk = ~clk;

    mux_reg_addr_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .ad_i(ad), .as_n_i(as_n), .ds_n_i(ds_n),
        .wr_i(wr), .chan_a_pin_i(pin), .reg_sel_o(reg_sel),
        .chan_a_o(chan_a), .cfg_sel_o(cfg_sel), .shift_right_o(shift_right)
    );

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0; as_n = 1'b1; ds_n = 1'b1; wr = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Address phase: strobe low one cycle, high one cycle, then sample.
    task automatic addr_phase(logic [7:0] a);
        @(negedge clk); ad = a; as_n = 1'b0;
        @(negedge clk); as_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic data_phase(logic is_wr, logic [7:0] d);
        @(negedge clk); ad = d; wr = is_wr; ds_n = 1'b0;
        @(negedge clk); ds_n = 1'b1; wr = 1'b0;
        @(negedge clk);
    endtask

    // Sweep every byte; expected fields are computed from the requirement.
    task automatic sweep(logic right, string req);
        for (int a = 0; a < 256; a++) begin
            logic [7:0] b = 8'(a);
            int exp_idx = right ? int'(b[5:2]) : int'(b[4:1]);
            int exp_ch  = right ? int'(b[0])   : int'(b[5]);
            addr_phase(b);
            for (int p = 0; p < 2; p++) begin
                pin = 1'(p); #1ns;
                check({req, " index"}, int'(reg_sel), exp_idx);
                check("R5 channel merge", int'(chan_a), exp_ch & p);
            end
            ad = ~b; @(negedge clk);
            check("R4 hold after bus change", int'(reg_sel), exp_idx);
        end
    endtask

    initial begin
        do_reset();
        @(negedge clk);
        check("R1 reset index", int'(reg_sel), 0);
        check("R1 reset mode", int'(shift_right), 0);
        check("R1 reset cfg select", int'(cfg_sel), 1);
        pin = 1'b1; #1ns; check("R1 reset chan pin A", int'(chan_a), 1);
        pin = 1'b0; #1ns; check("R1 reset chan pin B", int'(chan_a), 0);

        data_phase(1'b0, 8'hFF);
        check("R8 read keeps cfg open", int'(cfg_sel), 1);
        check("R8 read keeps mode", int'(shift_right), 0);

        sweep(1'b0, "R2");

        data_phase(1'b1, 8'h00);
        check("R6 cfg closed", int'(cfg_sel), 0);
        check("R6 mode loaded left", int'(shift_right), 0);
        data_phase(1'b1, 8'h01);
        check("R7 mode locked", int'(shift_right), 0);
        check("R7 cfg stays closed", int'(cfg_sel), 0);
        addr_phase(8'h3C);
        check("R7 still left decode", int'(reg_sel), 4'hE);

        do_reset();
        addr_phase(8'h3E);
        check("R2 pre-config index", int'(reg_sel), 4'hF);
        data_phase(1'b1, 8'h01);
        check("R6 mode loaded right", int'(shift_right), 1);
        check("R9 captured index kept", int'(reg_sel), 4'hF);
        addr_phase(8'h0E);
        check("R9 new address right index", int'(reg_sel), 4'h3);
        data_phase(1'b1, 8'h00);
        check("R7 right mode locked", int'(shift_right), 1);

        sweep(1'b1, "R3");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule